// File: doc/BRIEF.md
# SDR SDRAM Command Controller

This block drives a single rank of single-data-rate SDRAM that is 64 bits wide and built from four-bank devices. A user port presents one request at a time: read or write, bank, row, column, a 64-bit data word and a byte enable. The controller turns each request into a closed-page sequence. It opens the row, issues the column command and then closes the bank with a precharge. Every wait between two commands is a whole number of clocks, worked out from a nanosecond figure and the clock period by rounding up.

After reset the controller holds clock enable low and drives no-operation commands. It then waits a programmable number of cycles with clock enable high. Next it precharges all banks, issues two auto-refreshes and writes the mode register. A free-running timer raises a refresh request once per refresh interval. A pending refresh wins over any user request that is waiting in the idle state.

Writes place the user word on the first beat of a burst of four and mask the other three beats. Reads return the first beat of the burst on the user port with a one-cycle valid strobe, aligned to the CAS latency. The remaining beats are blanked through the data mask, which takes effect two clocks late on reads.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `sd_cke` is 0 and the command pins carry no-operation (cs_n,ras_n,cas_n,we_n = 0,1,1,1). `req_ready` is 0 until initialization is done.
- R2: Initialization issues at least INIT_CYCLES no-operations, then one precharge with address bit 10 high, then two auto-refreshes, then a mode-register write. The mode word puts the burst length code 010 (four beats) in address bits 2:0, 0 (sequential) in bit 3 and the CAS latency in bits 6:4. Only no-operations appear on the clock directly after the mode-register write.
- R3: Command encodings on (cs_n,ras_n,cas_n,we_n) are: mode set 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, no-operation 0111. `sd_ba` carries the request bank, with 00 through 11 selecting the four banks.
- R4: Each nanosecond minimum is converted to clocks as ceil(t/T_CK). Activate to read/write is at least the RAS-to-CAS count. Activate to precharge is at least the row-active count. Precharge to activate of a bank is at least the row-precharge count. Activate to activate is at least the row-cycle count, and at least the activate-to-activate count across banks.
- R5: A write drives the user word with `sd_dqm` = ~`req_be` on the same clock as the write command. The next three beats are driven with `sd_dqm` all ones. The precharge comes at least T_WR clocks after the last beat.
- R6: A read returns the data sampled CAS_LAT clocks after the read command. `rd_valid` is high for exactly one clock, CAS_LAT+1 clocks after the read command reaches the pins. `sd_dqm` is 0 two clocks before the first beat and all ones for the three beats after it (read mask latency 2).
- R7: A refresh is issued at least once per refresh interval plus the length of one access. A refresh is only issued with every bank precharged. A refresh that is due is served before a user request that is waiting.
- R8: A precharge that closes an access has address bit 10 low and carries the bank of that access. Read and write commands have address bit 10 low, so no auto-precharge is requested.
- R9: `req_ready` is high only in the idle state with no refresh pending. A request is taken on the clock where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | User request present |
| req_ready | output | 1 | Request taken this clock when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_wdata | input | DQ_W | Write data word |
| req_be | input | DQ_W/8 | Write byte enables, 1 = byte written |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DQ_W | Read data word |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Multiplexed address |
| sd_dqm | output | DQ_W/8 | Data mask per byte |
| sd_dq_out | output | DQ_W | Data driven to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DQ_W | Data returned from memory |

## Verification
A refresh that falls due and a user request that waits in the idle state can meet on the same clock. The controller must then pick the refresh, and only after the current row has been closed. The bench provokes this with a long run of back-to-back writes and reads at a shortened refresh interval. The refresh due point then lands at many different positions inside an access. A bus model in the bench counts every refresh issued while a bank was open and measures the largest gap between refreshes against the interval plus one access. It also checks that every read in the run returns the word written before it.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  // whole clocks covering a time given in ns
  function automatic int ns_to_clk(input int t_ns, input int tck_ns);
    return (t_ns + tck_ns - 1) / tck_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // mode word: burst of four, sequential order, CAS latency in bits 6:4
  function automatic logic [6:0] mode_bits(input int cl);
    logic [6:0] m;
    m      = 7'd0;
    m[2:0] = 3'b010;
    m[3]   = 1'b0;
    m[6:4] = 3'(cl);
    return m;
  endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int PERIOD = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  output logic pend_o
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !ack_i) |=> pend_o);

endmodule

// File: rtl/sdram_rd_align.sv
module sdram_rd_align #(
  parameter int CL   = 3,
  parameter int DQ_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_at_pins_i,
  input  logic [DQ_W-1:0] dq_i,
  output logic            blank_o,
  output logic            vld_o,
  output logic [DQ_W-1:0] data_o
);
  logic [CL:1] sh_q;
  logic [CL:0] tap;

  assign tap     = {sh_q, rd_at_pins_i};
  // beats 1..3 masked; read mask acts two clocks late
  assign blank_o = |tap[CL:CL-2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      sh_q  <= tap[CL-1:0];
      vld_o <= tap[CL];
      if (tap[CL]) data_o <= dq_i;
    end
  end

  // R6
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(rd_at_pins_i, CL + 1));

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl import sdram_ctrl_pkg::*; #(
  parameter int T_CK_NS     = 5,
  parameter int T_RCD_NS    = 24,
  parameter int T_RP_NS     = 24,
  parameter int T_RAS_NS    = 50,
  parameter int T_RC_NS     = 80,
  parameter int T_RRD_NS    = 20,
  parameter int T_REFI_NS   = 15625,
  parameter int INIT_CYCLES = 40000,
  parameter int T_MRD       = 2,
  parameter int T_WR        = 2,
  parameter int CAS_LAT     = 3,
  parameter int BURST       = 4,
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 12,
  parameter int COL_W       = 10,
  parameter int ADDR_W      = 12,
  parameter int DQ_W        = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]    req_row,
  input  logic [COL_W-1:0]    req_col,
  input  logic [DQ_W-1:0]     req_wdata,
  input  logic [DQ_W/8-1:0]   req_be,
  output logic                rd_valid,
  output logic [DQ_W-1:0]     rd_data,
  output logic                sd_cke,
  output logic                sd_cs_n,
  output logic                sd_ras_n,
  output logic                sd_cas_n,
  output logic                sd_we_n,
  output logic [BANK_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0]   sd_addr,
  output logic [DQ_W/8-1:0]   sd_dqm,
  output logic [DQ_W-1:0]     sd_dq_out,
  output logic                sd_dq_oe,
  input  logic [DQ_W-1:0]     sd_dq_in
);
  localparam int BE_W    = DQ_W / 8;
  localparam int AP_BIT  = 10;
  localparam int T_RCD   = ns_to_clk(T_RCD_NS, T_CK_NS);
  localparam int T_RP    = ns_to_clk(T_RP_NS, T_CK_NS);
  localparam int T_RAS   = ns_to_clk(T_RAS_NS, T_CK_NS);
  localparam int T_RC    = ns_to_clk(T_RC_NS, T_CK_NS);
  localparam int T_RRD   = ns_to_clk(T_RRD_NS, T_CK_NS);
  localparam int REF_CYC = ns_to_clk(T_REFI_NS, T_CK_NS);
  localparam int A2A     = imax(T_RC, T_RRD);
  // command-to-command gaps, at least 2 so the wait counter can load gap-2
  localparam int G_RCD    = imax(T_RCD, 2);
  localparam int G_RP     = imax(T_RP, 2);
  localparam int G_RC     = imax(A2A, 2);
  localparam int G_MRD    = imax(T_MRD, 2);
  localparam int G_COL_WR = imax(imax(T_RAS - T_RCD, BURST - 1 + T_WR), 2);
  localparam int G_COL_RD = imax(T_RAS - T_RCD, 2);
  localparam int G_PRE_WR = imax(imax(T_RP, A2A - G_RCD - G_COL_WR), 2);
  localparam int G_PRE_RD = imax(imax(T_RP, A2A - G_RCD - G_COL_RD), 2);
  localparam int WAIT_W   = $clog2(imax(INIT_CYCLES, A2A + T_RAS + T_RP) + 2);
  localparam int TAIL_W   = $clog2(BURST);

  typedef enum logic [2:0] {S_INIT, S_IPRE, S_IREF, S_IMRS, S_IDLE, S_COL, S_PRE, S_WAIT} st_e;

  st_e               st_q, st_d, ret_q, ret_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              iref_q, iref_d;
  logic [TAIL_W-1:0] tail_q, tail_d;
  logic              row_open_q;

  logic              rq_wr;
  logic [BANK_W-1:0] rq_bank;
  logic [ROW_W-1:0]  rq_row;
  logic [COL_W-1:0]  rq_col;
  logic [DQ_W-1:0]   rq_data;
  logic [BE_W-1:0]   rq_be;

  sd_cmd_e           cmd_d, cmd_q;
  logic [BANK_W-1:0] ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DQ_W-1:0]   dq_d;
  logic              oe_d;
  logic [BE_W-1:0]   dqm_d;

  // named events for checks
  logic ref_pend, ref_ack, accept, rd_at_pins, rd_blank;

  sdram_refresh_timer #(.PERIOD(REF_CYC)) u_ref (
    .clk(clk), .rst_n(rst_n), .ack_i(ref_ack), .pend_o(ref_pend));

  assign rd_at_pins = (cmd_q == CMD_RD);

  sdram_rd_align #(.CL(CAS_LAT), .DQ_W(DQ_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_at_pins_i(rd_at_pins), .dq_i(sd_dq_in),
    .blank_o(rd_blank), .vld_o(rd_valid), .data_o(rd_data));

  assign req_ready = (st_q == S_IDLE) && !ref_pend;
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d = st_q;  ret_d = ret_q;  wait_d = wait_q;  iref_d = iref_q;  tail_d = tail_q;
    cmd_d = CMD_NOP;  ba_d = '0;  addr_d = '0;  dq_d = '0;  oe_d = 1'b0;  dqm_d = '0;
    ref_ack = 1'b0;
    if (tail_q != '0) begin
      oe_d = 1'b1;  dqm_d = '1;  tail_d = tail_q - 1'b1;
    end
    case (st_q)
      S_INIT: if (wait_q == '0) st_d = S_IPRE; else wait_d = wait_q - 1'b1;
      S_IPRE: begin
        cmd_d = CMD_PRE;  addr_d[AP_BIT] = 1'b1;
        st_d = S_WAIT;  ret_d = S_IREF;  wait_d = WAIT_W'(G_RP - 2);
      end
      S_IREF: begin
        cmd_d = CMD_REF;  ref_ack = 1'b1;  iref_d = ~iref_q;
        st_d = S_WAIT;  ret_d = iref_q ? S_IMRS : S_IREF;  wait_d = WAIT_W'(G_RC - 2);
      end
      S_IMRS: begin
        cmd_d = CMD_MRS;  addr_d[6:0] = mode_bits(CAS_LAT);
        st_d = S_WAIT;  ret_d = S_IDLE;  wait_d = WAIT_W'(G_MRD - 2);
      end
      S_IDLE: begin
        if (ref_pend) begin
          cmd_d = CMD_REF;  ref_ack = 1'b1;
          st_d = S_WAIT;  ret_d = S_IDLE;  wait_d = WAIT_W'(G_RC - 2);
        end else if (req_valid) begin
          cmd_d = CMD_ACT;  ba_d = req_bank;  addr_d[ROW_W-1:0] = req_row;
          st_d = S_WAIT;  ret_d = S_COL;  wait_d = WAIT_W'(G_RCD - 2);
        end
      end
      S_COL: begin
        cmd_d = rq_wr ? CMD_WR : CMD_RD;  ba_d = rq_bank;  addr_d[COL_W-1:0] = rq_col;
        if (rq_wr) begin
          oe_d = 1'b1;  dq_d = rq_data;  dqm_d = ~rq_be;  tail_d = TAIL_W'(BURST - 1);
        end
        st_d = S_WAIT;  ret_d = S_PRE;
        wait_d = rq_wr ? WAIT_W'(G_COL_WR - 2) : WAIT_W'(G_COL_RD - 2);
      end
      S_PRE: begin
        cmd_d = CMD_PRE;  ba_d = rq_bank;
        st_d = S_WAIT;  ret_d = S_IDLE;
        wait_d = rq_wr ? WAIT_W'(G_PRE_WR - 2) : WAIT_W'(G_PRE_RD - 2);
      end
      S_WAIT: if (wait_q == '0) st_d = ret_q; else wait_d = wait_q - 1'b1;
      default: st_d = S_INIT;
    endcase
    dqm_d = dqm_d | {BE_W{rd_blank}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_INIT;  ret_q <= S_INIT;  wait_q <= WAIT_W'(INIT_CYCLES - 1);
      iref_q <= 1'b0;  tail_q <= '0;  row_open_q <= 1'b0;
      cmd_q <= CMD_NOP;  sd_ba <= '0;  sd_addr <= '0;  sd_dq_out <= '0;
      sd_dq_oe <= 1'b0;  sd_dqm <= '0;  sd_cke <= 1'b0;
      rq_wr <= 1'b0;  rq_bank <= '0;  rq_row <= '0;  rq_col <= '0;  rq_data <= '0;  rq_be <= '0;
    end else begin
      st_q <= st_d;  ret_q <= ret_d;  wait_q <= wait_d;  iref_q <= iref_d;  tail_q <= tail_d;
      cmd_q <= cmd_d;  sd_ba <= ba_d;  sd_addr <= addr_d;  sd_dq_out <= dq_d;
      sd_dq_oe <= oe_d;  sd_dqm <= dqm_d;  sd_cke <= 1'b1;
      if (cmd_d == CMD_ACT)      row_open_q <= 1'b1;
      else if (cmd_d == CMD_PRE) row_open_q <= 1'b0;
      if (accept) begin
        rq_wr <= req_write;  rq_bank <= req_bank;  rq_row <= req_row;
        rq_col <= req_col;  rq_data <= req_wdata;  rq_be <= req_be;
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  // R7
  ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_d == CMD_REF) |-> !row_open_q);
  // R4
  act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_d == CMD_ACT) |-> !row_open_q);
  // R2
  mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP));
  // R9
  ready_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ref_pend);

endmodule

// File: tb/sdram_cmd_ctrl_tb.sv
module sdram_cmd_ctrl_tb_top;
  localparam int TCK = 5, CL = 3, INIT = 20, REFI_NS = 2000;

  function automatic int cdiv(input int t, input int c);
    int q;
    q = t / c;
    if (q * c < t) q++;
    return q;
  endfunction

  localparam int E_RCD = cdiv(24, TCK), E_RP = cdiv(24, TCK), E_RAS = cdiv(50, TCK);
  localparam int E_RC = cdiv(80, TCK), E_RRD = cdiv(20, TCK), E_REF = cdiv(REFI_NS, TCK);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready, rd_valid;
  logic [1:0] req_bank = '0;
  logic [11:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic [63:0] req_wdata = '0, rd_data, dq_out;
  logic [7:0] req_be = '0, dqm;
  logic cke, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [1:0] ba;
  logic [11:0] addr;
  logic [63:0] dq_in = '0;

  sdram_cmd_ctrl #(.T_CK_NS(TCK), .T_REFI_NS(REFI_NS), .INIT_CYCLES(INIT), .CAS_LAT(CL)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cke(cke), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ba(ba), .sd_addr(addr), .sd_dqm(dqm), .sd_dq_out(dq_out), .sd_dq_oe(dq_oe),
    .sd_dq_in(dq_in));

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- bus model ----------------
  logic [63:0] mem [int];
  int ec = 0;
  bit open_b [4];
  int act_e [4], pre_e [4];
  int last_act = -1000, last_mrs = -1000, wr_end = -1000;
  int vio_t = 0, vio_tail = 0, vio_rdm = 0, vio_rdv = 0, vio_ref = 0, vio_a10 = 0, vio_mrs = 0;
  int rd_e = -1000, rd_key = 0, rd_seen = 0, tail_n = 0, tail_key = 0;
  int last_ref = -1, max_ref_gap = 0, ref_n = 0, first_pre = -1;
  logic [3:0] log_cmd [8];
  logic [11:0] log_addr [8];
  int log_n = 0;

  initial for (int i = 0; i < 4; i++) begin act_e[i] = -1000; pre_e[i] = -1000; open_b[i] = 0; end

  function automatic int key(input logic [1:0] b, input logic [11:0] r, input logic [9:0] c);
    return int'({b, r, c});
  endfunction

  function automatic logic [63:0] rdm(input int k);
    return mem.exists(k) ? mem[k] : 64'h0;
  endfunction

  task automatic merge(input int k, input logic [63:0] d, input logic [7:0] m);
    logic [63:0] v;
    v = rdm(k);
    for (int i = 0; i < 8; i++) if (!m[i]) v[i*8 +: 8] = d[i*8 +: 8];
    mem[k] = v;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      logic [3:0] c;
      ec++;
      c = {cs_n, ras_n, cas_n, we_n};
      if (tail_n > 0) begin
        if (dqm != 8'hFF) vio_tail++;
        tail_key++;
        merge(tail_key, dq_out, dqm);
        tail_n--;
      end
      if (c != 4'b0111) begin
        if (log_n < 8) begin log_cmd[log_n] = c; log_addr[log_n] = addr; log_n++; end
        if (ec - last_mrs < 2) vio_mrs++;
      end
      case (c)
        4'b0000: begin last_mrs = ec; for (int i = 0; i < 4; i++) if (open_b[i]) vio_t++; end
        4'b0001: begin
          for (int i = 0; i < 4; i++) if (open_b[i]) vio_ref++;
          if (last_ref >= 0 && log_n > 4 && ec - last_ref > max_ref_gap) max_ref_gap = ec - last_ref;
          last_ref = ec;  ref_n++;
        end
        4'b0011: begin
          if (open_b[ba] || ec - pre_e[ba] < E_RP || ec - act_e[ba] < E_RC || ec - last_act < E_RRD) vio_t++;
          open_b[ba] = 1;  act_e[ba] = ec;  last_act = ec;
        end
        4'b0010: begin
          if (first_pre < 0) first_pre = ec;
          if (addr[10]) begin
            for (int i = 0; i < 4; i++) begin open_b[i] = 0; pre_e[i] = ec; end
          end else begin
            if (!open_b[ba] || ec - act_e[ba] < E_RAS || ec - wr_end < 2) vio_t++;
            open_b[ba] = 0;  pre_e[ba] = ec;
          end
        end
        4'b0100, 4'b0101: begin
          if (!open_b[ba] || ec - act_e[ba] < E_RCD) vio_t++;
          if (addr[10]) vio_a10++;
          if (c == 4'b0100) begin
            tail_key = key(ba, 12'(dut_i.rq_row), addr[9:0]);
            merge(tail_key, dq_out, dqm);
            tail_n = 3;  wr_end = ec + 3;
          end else begin
            rd_e = ec;  rd_key = key(ba, 12'(dut_i.rq_row), addr[9:0]);
          end
        end
        default: ;
      endcase
      if (ec == rd_e + CL - 2 && dqm != 8'h00) vio_rdm++;
      if (ec >= rd_e + CL - 1 && ec <= rd_e + CL + 1 && dqm != 8'hFF) vio_rdm++;
      if (ec == rd_e + CL - 1) dq_in <= rdm(rd_key);
      if (rd_valid) begin
        rd_seen++;
        if (ec != rd_e + CL + 1) vio_rdv++;
      end
    end
  end

  // ---------------- user port tasks ----------------
  task automatic do_req(input bit w, input logic [1:0] b, input logic [11:0] r,
                        input logic [9:0] c, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    req_valid = 1'b1;  req_write = w;  req_bank = b;  req_row = r;  req_col = c;
    req_wdata = d;  req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 ready drops after accept", 64'(req_ready), 64'd0);
  endtask

  task automatic rd_word(input logic [1:0] b, input logic [11:0] r, input logic [9:0] c,
                         output logic [63:0] d);
    int t;
    do_req(1'b0, b, r, c, '0, '0);
    t = 0;
    while (!rd_valid && t < 100) begin @(negedge clk); t++; end
    d = rd_data;
    @(negedge clk);
    chk(!rd_valid, "R6 valid lasts one clock", 64'(rd_valid), 64'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(cke == 1'b0, "R1 cke low in reset", 64'(cke), 64'd0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 nop in reset", 64'({cs_n, ras_n, cas_n, we_n}), 64'h7);
    chk(!req_ready, "R9 not ready in reset", 64'(req_ready), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 nop after reset", 64'({cs_n, ras_n, cas_n, we_n}), 64'h7);
    chk(!req_ready, "R1 not ready during init", 64'(req_ready), 64'd0);
  endtask

  task automatic t_init();
    int t;
    t = 0;
    while (!req_ready && t < 500) begin @(negedge clk); t++; end
    chk(req_ready, "R9 ready after init", 64'(req_ready), 64'd1);
    chk(first_pre >= INIT, "R2 nop count before precharge", 64'(first_pre), 64'(INIT));
    chk(log_cmd[0] == 4'b0010 && log_addr[0][10], "R2 precharge all first", 64'({log_cmd[0], log_addr[0]}), 64'h2400);
    chk(log_cmd[1] == 4'b0001 && log_cmd[2] == 4'b0001, "R2 two refreshes", 64'({log_cmd[1], log_cmd[2]}), 64'h11);
    chk(log_cmd[3] == 4'b0000, "R3 mode set code", 64'(log_cmd[3]), 64'h0);
    chk(log_addr[3] == 12'((CL << 4) | 2), "R2 mode word", 64'(log_addr[3]), 64'((CL << 4) | 2));
  endtask

  task automatic t_rw_basic();
    logic [63:0] d;
    do_req(1'b1, 2'd1, 12'h123, 10'h040, 64'h0123_4567_89AB_CDEF, 8'hFF);
    rd_word(2'd1, 12'h123, 10'h040, d);
    chk(d == 64'h0123_4567_89AB_CDEF, "R6 read returns written word", d, 64'h0123_4567_89AB_CDEF);
    chk(vio_rdv == 0 && rd_seen == 1, "R6 valid aligned to latency", 64'(vio_rdv), 64'd0);
    chk(vio_rdm == 0, "R6 read mask pattern", 64'(vio_rdm), 64'd0);
  endtask

  task automatic t_byte_mask();
    logic [63:0] d;
    do_req(1'b1, 2'd2, 12'h055, 10'h011, 64'h5555_5555_5555_5555, 8'hFF);
    do_req(1'b1, 2'd2, 12'h055, 10'h010, 64'h1111_1111_1111_1111, 8'hFF);
    do_req(1'b1, 2'd2, 12'h055, 10'h010, 64'hAAAA_AAAA_AAAA_AAAA, 8'h0F);
    rd_word(2'd2, 12'h055, 10'h010, d);
    chk(d == 64'h1111_1111_AAAA_AAAA, "R5 byte enables", d, 64'h1111_1111_AAAA_AAAA);
    rd_word(2'd2, 12'h055, 10'h011, d);
    chk(d == 64'h5555_5555_5555_5555, "R5 tail beats masked", d, 64'h5555_5555_5555_5555);
    chk(vio_tail == 0, "R5 tail mask all ones", 64'(vio_tail), 64'd0);
  endtask

  task automatic t_banks();
    logic [63:0] d;
    for (int b = 0; b < 4; b++)
      do_req(1'b1, 2'(b), 12'h200, 10'h100, 64'hB0B0_0000_0000_0000 + 64'(b), 8'hFF);
    for (int b = 3; b >= 0; b--) begin
      rd_word(2'(b), 12'h200, 10'h100, d);
      chk(d == 64'hB0B0_0000_0000_0000 + 64'(b), "R3 bank select", d, 64'hB0B0_0000_0000_0000 + 64'(b));
    end
  endtask

  task automatic t_collide();
    logic [63:0] d;
    int bad, r0;
    bad = 0;
    r0 = ref_n;
    for (int i = 0; i < 40; i++) begin
      do_req(1'b1, 2'(i), 12'(i * 7), 10'(i * 4), 64'hC0DE_0000_0000_0000 ^ 64'(i * 1001), 8'hFF);
      rd_word(2'(i), 12'(i * 7), 10'(i * 4), d);
      if (d != (64'hC0DE_0000_0000_0000 ^ 64'(i * 1001))) bad++;
    end
    chk(bad == 0, "R7 data intact across refresh", 64'(bad), 64'd0);
    chk(vio_ref == 0, "R7 refresh with banks closed", 64'(vio_ref), 64'd0);
    chk(max_ref_gap > 0 && max_ref_gap <= E_REF + 40, "R7 refresh interval bound", 64'(max_ref_gap), 64'(E_REF));
    repeat (2 * E_REF) @(negedge clk);
    chk(ref_n - r0 >= 4, "R7 refresh count", 64'(ref_n - r0), 64'd4);
  endtask

  task automatic t_timing();
    chk(vio_t == 0, "R4 minimum command gaps", 64'(vio_t), 64'd0);
    chk(vio_a10 == 0, "R8 no auto-precharge", 64'(vio_a10), 64'd0);
    chk(vio_mrs == 0, "R2 gap after mode set", 64'(vio_mrs), 64'd0);
  endtask

  initial begin
    t_reset();
    t_init();
    t_rw_basic();
    t_byte_mask();
    t_banks();
    t_collide();
    t_timing();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;  fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule